// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a watchdog counter controlled through one 16-bit register on a simple register bus. The counter advances on single-cycle tick pulses taken from one of two tick sources. In watchdog mode, letting the count reach the selected interval produces a one-cycle system reset pulse. In interval mode the same event sets a sticky interrupt flag instead, and counting carries on.

Every write to the register is key-checked. A write without the correct key byte, or one that does not drive both byte lanes, counts as a tampering attempt and resets the system at once. A cause output records whether the last reset came from a timeout or from a key violation. Two control bits pass straight through as configuration for an external reset/NMI pin.

Top module: `wdt_guard`

## Requirements
- R1: A read returns 0x69 in bits 15:8 and the control byte in bits 7:0. Bit 3 always reads back as 0.
- R2: After `rst_n` the control byte is 0x00 and the count is 0. That state is: counting enabled, watchdog mode, subsystem ticks, 32768-count interval. `sys_rst`, `irq_flag` and `cause_key` are all 0.
- R3: A write takes effect only when both byte enables are set (`wr_be`=2'b11) and bits 15:8 equal 0x5A. The new control byte can be read in the following cycle.
- R4: Any other write makes `sys_rst` high for exactly one cycle, starting in the cycle after the write. In that case `cause_key` becomes 1, the control byte returns to 0x00 and the count is cleared. This happens whatever the mode is.
- R5: Control bit 2 picks the tick source: 0 counts `tick_sub`, 1 counts `tick_aux`. The unselected source has no effect.
- R6: Control bits 1:0 set the interval in counted ticks: 00 gives 32768, 01 gives 8192, 10 gives 512 and 11 gives 64.
- R7: In watchdog mode (bit 4 = 0), the tick that completes the interval makes `sys_rst` high for one cycle in the next cycle. It also sets `cause_key` to 0, returns the control byte to 0x00 and clears the count.
- R8: In interval mode (bit 4 = 1), completing the interval sets `irq_flag` and restarts the count from 0, with no reset. `irq_flag` stays set until `irq_clr` is asserted. If a set and a clear occur in the same cycle, the set wins.
- R9: While control bit 7 (hold) is 1, ticks are not counted.
- R10: A valid write with bit 3 = 1 clears the count, and no expiry occurs in that cycle. The bit itself is never stored.
- R11: Control bit 6 drives `nmi_fall` (1 = falling edge). Control bit 5 drives `nmi_sel`.
- R12: When a tick completes a watchdog interval in the same cycle as a valid write that does not clear the count, the timeout wins. Within any write cycle, counting follows the control value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sub | input | 1 | Subsystem tick pulse |
| tick_aux | input | 1 | Auxiliary tick pulse |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte-lane enables (bit 1 = upper) |
| wr_data | input | 16 | Write data, key in bits 15:8 |
| rd_data | output | 16 | Register read value |
| irq_clr | input | 1 | Clears the interval flag |
| irq_flag | output | 1 | Sticky interval interrupt flag |
| sys_rst | output | 1 | One-cycle system reset request |
| cause_key | output | 1 | Last reset cause: 1 key violation, 0 timeout |
| nmi_sel | output | 1 | Pin function select bit |
| nmi_fall | output | 1 | Pin edge select bit |

## Verification
Every registered result lands one cycle after the edge that samples its stimulus: a written control byte, a key-violation or timeout pulse on `sys_rst`, and the setting or clearing of `irq_flag`. The bench drives inputs on the falling edge and advances a reference model at the rising edge. It then compares all outputs on the following falling edge, so every comparison sits exactly one register stage after its cause. Interval lengths are measured by counting ticked cycles until the pulse appears, which gives 64, 512, 8192 and 32768.

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int          CNT_W  = 16,
  parameter logic [7:0]  WR_KEY = 8'h5A,
  parameter logic [7:0]  RD_KEY = 8'h69
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_sub,
  input  logic        tick_aux,
  input  logic        wr_en,
  input  logic [1:0]  wr_be,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        irq_clr,
  output logic        irq_flag,
  output logic        sys_rst,
  output logic        cause_key,
  output logic        nmi_sel,
  output logic        nmi_fall
);
  localparam int TAP0 = CNT_W - 1;
  localparam int TAP1 = CNT_W - 3;
  localparam int TAP2 = CNT_W - 7;
  localparam int TAP3 = CNT_W - 10;
  localparam logic [CNT_W-1:0] LAST0 = CNT_W'((64'd1 << TAP0) - 64'd1);
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'((64'd1 << TAP1) - 64'd1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'((64'd1 << TAP2) - 64'd1);
  localparam logic [CNT_W-1:0] LAST3 = CNT_W'((64'd1 << TAP3) - 64'd1);

  logic [7:0]       ctrl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             bad_wr, good_wr, kick, step, hit;

  assign bad_wr  = wr_en && (wr_be != 2'b11 || wr_data[15:8] != WR_KEY);
  assign good_wr = wr_en && !bad_wr;
  assign kick    = good_wr && wr_data[3];
  assign step    = !ctrl[7] && (ctrl[2] ? tick_aux : tick_sub);

  always_comb begin
    case (ctrl[1:0])
      2'b00:   last = LAST0;
      2'b01:   last = LAST1;
      2'b10:   last = LAST2;
      default: last = LAST3;
    endcase
  end

  assign hit      = step && (cnt == last) && !kick;
  assign rd_data  = {RD_KEY, ctrl};
  assign nmi_fall = ctrl[6];
  assign nmi_sel  = ctrl[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      cnt       <= '0;
      irq_flag  <= 1'b0;
      sys_rst   <= 1'b0;
      cause_key <= 1'b0;
    end else begin
      sys_rst <= 1'b0;
      if (irq_clr) irq_flag <= 1'b0;
      if (bad_wr) begin
        sys_rst   <= 1'b1;
        cause_key <= 1'b1;
        ctrl      <= '0;
        cnt       <= '0;
      end else if (hit && !ctrl[4]) begin
        sys_rst   <= 1'b1;
        cause_key <= 1'b0;
        ctrl      <= '0;
        cnt       <= '0;
      end else begin
        if (good_wr) ctrl <= wr_data[7:0] & 8'hF7;
        if (kick)      cnt <= '0;
        else if (hit)  cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
        if (hit) irq_flag <= 1'b1;
      end
    end
  end
endmodule

module wdt_guard_chk #(parameter int CNT_W = 16) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_be,
  input logic [15:0]      wr_data,
  input logic [15:0]      rd_data,
  input logic             irq_flag,
  input logic             sys_rst,
  input logic             cause_key,
  input logic [CNT_W-1:0] cnt
);
  p_key_viol_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_be != 2'b11 || wr_data[15:8] != 8'h5A) |=> sys_rst && cause_key);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst && !wr_en |=> !sys_rst);

  p_defaults_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> rd_data[7:0] == 8'h00 && cnt == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] && !wr_en |=> $stable(cnt));

  p_irq_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(rd_data[4]));
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
  .rd_data(rd_data), .irq_flag(irq_flag), .sys_rst(sys_rst),
  .cause_key(cause_key), .cnt(cnt)
);

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_sub = 0, tick_aux = 0, wr_en = 0, irq_clr = 0;
  logic [1:0]  wr_be = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        irq_flag, sys_rst, cause_key, nmi_sel, nmi_fall;

  int compared = 0, mismatched = 0, cyc = 0;
  string tag = "R2";

  logic [7:0] m_ctrl = 0;
  int         m_cnt = 0;
  logic       m_irq = 0, m_rst = 0, m_key = 0;

  always #10 clk = ~clk;

  wdt_guard u_dut (
    .clk(clk), .rst_n(rst_n), .tick_sub(tick_sub), .tick_aux(tick_aux),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
    .irq_clr(irq_clr), .irq_flag(irq_flag), .sys_rst(sys_rst),
    .cause_key(cause_key), .nmi_sel(nmi_sel), .nmi_fall(nmi_fall)
  );

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      mismatched++;
      $display("FAIL watchdog act=%0d exp<190000", cyc);
      finish_run();
    end
  end

  task automatic chk(string t, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s act=%0h exp=%0h", t, what, act, exp);
    end
  endtask

  function automatic int span(logic [1:0] s);
    case (s)
      2'b00: return 32768;
      2'b01: return 8192;
      2'b10: return 512;
      default: return 64;
    endcase
  endfunction

  task automatic model();
    logic bad, good, clr, stp, hit;
    bad  = wr_en && (wr_be != 2'b11 || wr_data[15:8] != 8'h5A);
    good = wr_en && !bad;
    clr  = good && wr_data[3];
    stp  = !m_ctrl[7] && (m_ctrl[2] ? tick_aux : tick_sub);
    hit  = stp && (m_cnt == span(m_ctrl[1:0]) - 1) && !clr;
    m_rst = 0;
    if (irq_clr) m_irq = 0;
    if (bad) begin m_rst = 1; m_key = 1; m_ctrl = 0; m_cnt = 0; end
    else if (hit && !m_ctrl[4]) begin m_rst = 1; m_key = 0; m_ctrl = 0; m_cnt = 0; end
    else begin
      if (good) m_ctrl = wr_data[7:0] & 8'hF7;
      if (clr || hit) m_cnt = 0;
      else if (stp) m_cnt = m_cnt + 1;
      if (hit) m_irq = 1;
    end
  endtask

  task automatic step(logic ts, logic ta, logic we, logic [1:0] be, logic [15:0] d, logic ic);
    tick_sub = ts; tick_aux = ta; wr_en = we; wr_be = be; wr_data = d; irq_clr = ic;
    @(posedge clk);
    model();
    @(negedge clk);
    chk(tag, "rd_data", rd_data, {8'h69, m_ctrl});
    chk(tag, "sys_rst", sys_rst, m_rst);
    chk(tag, "cause_key", cause_key, m_key);
    chk(tag, "irq_flag", irq_flag, m_irq);
    chk(tag, "nmi", {nmi_fall, nmi_sel}, m_ctrl[6:5]);
  endtask

  task automatic wr(logic [15:0] d);
    step(0, 0, 1, 2'b11, d, 0);
  endtask

  task automatic ticks(int n, logic ts, logic ta);
    for (int i = 0; i < n; i++) step(ts, ta, 0, 0, 0, 0);
  endtask

  task automatic until_rst(string t, int exp);
    int n = 0;
    for (int i = 1; i <= 40000; i++) begin
      step(1, 0, 0, 0, 0, 0);
      if (sys_rst) begin n = i; break; end
    end
    chk(t, "ticks to timeout", n, exp);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2", "rd_data", rd_data, 16'h6900);
    chk("R2", "outs", {sys_rst, irq_flag, cause_key}, 3'b000);
    rst_n = 1'b1;

    tag = "R3"; wr(16'h5A80);
    chk("R1", "key byte", rd_data[15:8], 8'h69);
    chk("R3", "ctrl", rd_data[7:0], 8'h80);
    tag = "R10"; wr(16'h5A88);
    chk("R10", "clear bit reads 0", rd_data[3], 0);
    tag = "R11"; wr(16'h5A60);
    chk("R11", "nmi bits", {nmi_fall, nmi_sel}, 2'b11);

    tag = "R8"; wr(16'h5A13);
    ticks(63, 1, 0);
    chk("R8", "irq before", irq_flag, 0);
    ticks(1, 1, 0);
    chk("R8", "irq set", irq_flag, 1);
    ticks(64, 1, 0);
    chk("R8", "no reset in interval", sys_rst, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R8", "irq cleared", irq_flag, 0);

    tag = "R5"; wr(16'h5A17);
    ticks(100, 1, 0);
    chk("R5", "sub ignored", irq_flag, 0);
    ticks(64, 0, 1);
    chk("R5", "aux counted", irq_flag, 1);
    step(0, 0, 0, 0, 0, 1);

    tag = "R9"; wr(16'h5A93);
    ticks(200, 1, 0);
    chk("R9", "held", irq_flag, 0);

    tag = "R10"; wr(16'h5A13);
    ticks(40, 1, 0);
    wr(16'h5A1B);
    ticks(63, 1, 0);
    chk("R10", "irq after clear", irq_flag, 0);
    ticks(1, 1, 0);
    chk("R10", "irq late", irq_flag, 1);
    step(0, 0, 0, 0, 0, 1);

    tag = "R7"; wr(16'h5A03);
    until_rst("R7", 64);
    chk("R7", "cause timeout", cause_key, 0);
    chk("R7", "ctrl default", rd_data, 16'h6900);
    tag = "R6"; wr(16'h5A02); until_rst("R6", 512);
    wr(16'h5A01); until_rst("R6", 8192);
    wr(16'h5A00); until_rst("R6", 32768);

    tag = "R4"; wr(16'h5A13); wr(16'h1213);
    chk("R4", "bad key rst", {sys_rst, cause_key}, 2'b11);
    chk("R4", "ctrl default", rd_data, 16'h6900);
    step(0, 0, 0, 0, 0, 0);
    chk("R4", "pulse ends", sys_rst, 0);
    wr(16'h5A13);
    step(0, 0, 1, 2'b01, 16'h5A13, 0);
    chk("R4", "byte write rst", {sys_rst, cause_key}, 2'b11);

    tag = "R12"; wr(16'h5A03);
    ticks(63, 1, 0);
    step(1, 0, 1, 2'b11, 16'h5A10, 0);
    chk("R12", "timeout wins", {sys_rst, rd_data[7:0]}, 9'h100);

    tag = "R1";
    for (int i = 0; i < 4000; i++) begin
      logic we, ic;
      logic [1:0] be;
      logic [15:0] d;
      we = ($urandom % 16) == 0;
      ic = ($urandom % 16) == 0;
      be = (($urandom % 8) == 0) ? 2'($urandom) : 2'b11;
      d[15:8] = (($urandom % 8) == 0) ? 8'($urandom) : 8'h5A;
      d[7:0]  = 8'($urandom) & 8'h7F;
      if (($urandom % 8) != 0) d[1:0] = 2'b11;
      step(1'($urandom), 1'($urandom), we, be, d, ic);
    end
    finish_run();
  end
endmodule